// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block decides which analog input an 8-bit multi-channel converter samples next, and in what order. A host sets a 2-bit scan mode and a channel-select field, then pulses `start`. The block copies that configuration and walks through a list of channel indices. For each index it raises a convert request and keeps it raised until the converter answers with a one-cycle done strobe. Each returned 8-bit sample is captured together with the channel it belongs to. When the list is exhausted, the block pulses `seq_done` and goes back to idle.

Four orderings are available:
- an ascending sweep from channel 0;
- an eight-fold repeat of one channel;
- an ascending sweep that begins at a fixed mid-range channel;
- a single conversion.

In external-clock operation, the repeat and single modes both convert the selected channel without end, until the host signals not-acknowledge. A not-acknowledge in any mode stops the run once the conversion in progress has finished.

The parameter `NUM_CH` builds either a 4-input variant or a 12-input variant. The 4-input variant has a 2-bit select and starts its mid-range sweep at channel 2. The 12-input variant has a 4-bit select and starts its mid-range sweep at channel 6.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset `conv_req`, `busy`, `seq_done` and `result_valid` are all 0, and `conv_req` is never 1 while `busy` is 0.
- R2: Mode 2'b00 converts channels 0, 1, … up to the selected channel, in ascending order. A selected channel of 0 gives a single conversion of channel 0.
- R3: Mode 2'b01 with `ext_clk`=0 converts the selected channel exactly 8 times.
- R4: Mode 2'b10 converts in ascending order from the start channel (2 when `NUM_CH`=4, 6 when `NUM_CH`=12) up to the selected channel.
- R5: Mode 2'b10 with a selected channel at or below the start channel converts only the start channel, once.
- R6: Mode 2'b11 with `ext_clk`=0 converts the selected channel once.
- R7: A selected channel above `NUM_CH`-1 is treated as `NUM_CH`-1, and `conv_ch` never exceeds `NUM_CH`-1 while `conv_req` is 1.
- R8: With `ext_clk`=1, modes 2'b01 and 2'b11 both convert the selected channel repeatedly until `nack` is seen.
- R9: A `nack` seen while busy (in any mode) ends the run after the conversion in progress completes. A `nack` while idle has no effect on the next run.
- R10: `conv_req` and `conv_ch` stay unchanged until a cycle with `conv_done`=1. Each such cycle completes exactly one conversion.
- R11: The run ends with `seq_done` high for exactly one cycle. In that cycle `busy` and `conv_req` are already 0.
- R12: `scan_mode`, `ch_sel` and `ext_clk` are sampled only by a `start` while idle. A `start` or a configuration change during a run has no effect on that run.
- R13: One cycle after a completed conversion, `result_valid` is 1 for one cycle, with `result_data` holding the 8-bit `conv_data` and `result_ch` holding the channel converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle, latching the configuration |
| scan_mode | input | 2 | Channel ordering: 00 sweep from 0, 01 repeat 8x, 10 sweep from mid start, 11 single |
| ch_sel | input | SEL_W (2 or 4) | Selected (highest or only) channel |
| ext_clk | input | 1 | External-clock operation: modes 01 and 11 run until not-acknowledge |
| nack | input | 1 | Not-acknowledge from the host; ends the run after the current conversion |
| conv_done | input | 1 | Converter finished the requested conversion |
| conv_data | input | DATA_W (8) | Converter sample, valid with `conv_done` |
| conv_req | output | 1 | Conversion request |
| conv_ch | output | SEL_W | Channel to convert, valid while `conv_req` is 1 |
| busy | output | 1 | A run is in progress |
| seq_done | output | 1 | One-cycle end-of-run pulse |
| result_valid | output | 1 | Captured sample available this cycle |
| result_ch | output | SEL_W | Channel of the captured sample |
| result_data | output | DATA_W | Captured sample |

## Verification
The bench builds two copies of the block. The 12-input variant (`NUM_CH`=12) is used for every mode, and because its 4-bit select can name channels 12 to 15, it also reaches the clamping case. A 4-input variant (`NUM_CH`=4) is built beside it to show that the mid-range sweep starts at channel 2 and clamps there. With only two select bits, its clamp logic drops out and the select field is always in range.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;

  typedef enum logic [1:0] {
    SCAN_FROM_ZERO = 2'b00,
    SCAN_REPEAT    = 2'b01,
    SCAN_FROM_MID  = 2'b10,
    SCAN_ONE       = 2'b11
  } scan_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seq_state_e;

  function automatic int sel_width(input int num_ch);
    return (num_ch > 4) ? 4 : 2;
  endfunction

  function automatic int mid_start(input int num_ch);
    return (num_ch > 4) ? 6 : 2;
  endfunction

endpackage

// File: rtl/adc_scan_cfg.sv
`timescale 1ns/1ps
module adc_scan_cfg
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 12,
  parameter int SEL_W    = 4,
  parameter int START_CH = 6
) (
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_clk,
  output logic [SEL_W-1:0] first_ch,
  output logic [SEL_W-1:0] last_ch,
  output logic             endless,
  output logic             rep_mode
);

  localparam logic [SEL_W-1:0] MAX_CH  = SEL_W'(NUM_CH - 1);
  localparam logic [SEL_W-1:0] MID_CH  = SEL_W'(START_CH);

  logic [SEL_W-1:0] sel_c;

  // Out-of-range selects only exist when the field can name more channels than exist
  generate
    if (NUM_CH < (1 << SEL_W)) begin : g_clamp
      assign sel_c = (sel > MAX_CH) ? MAX_CH : sel;
    end else begin : g_noclamp
      assign sel_c = sel;
    end
  endgenerate

  always_comb begin
    first_ch = '0;
    last_ch  = sel_c;
    endless  = 1'b0;
    rep_mode = 1'b0;
    case (scan_mode_e'(mode))
      SCAN_FROM_ZERO: begin
        first_ch = '0;
        last_ch  = sel_c;
      end
      SCAN_REPEAT: begin
        first_ch = sel_c;
        last_ch  = sel_c;
        rep_mode = ~ext_clk;
        endless  = ext_clk;
      end
      SCAN_FROM_MID: begin
        first_ch = MID_CH;
        last_ch  = (sel_c > MID_CH) ? sel_c : MID_CH;
      end
      SCAN_ONE: begin
        first_ch = sel_c;
        last_ch  = sel_c;
        endless  = ext_clk;
      end
      default: begin
        first_ch = '0;
        last_ch  = sel_c;
      end
    endcase
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
`timescale 1ns/1ps
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int REPEAT_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] first_ch,
  input  logic [SEL_W-1:0] last_ch,
  input  logic             endless,
  input  logic             rep_mode,
  input  logic             nack,
  input  logic             conv_done,
  output logic             conv_req,
  output logic [SEL_W-1:0] conv_ch,
  output logic             busy,
  output logic             seq_done
);

  localparam int CNT_W = (REPEAT_N > 1) ? $clog2(REPEAT_N) : 1;
  localparam logic [CNT_W-1:0] REP_LAST = CNT_W'(REPEAT_N - 1);

  seq_state_e       state;
  logic [SEL_W-1:0] last_q;
  logic             endless_q;
  logic             rep_q;
  logic [CNT_W-1:0] rep_cnt;
  logic             nack_seen;
  logic             finish;

  always_comb begin
    if (nack || nack_seen) finish = 1'b1;
    else if (endless_q)    finish = 1'b0;
    else if (rep_q)        finish = (rep_cnt == REP_LAST);
    else                   finish = (conv_ch == last_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      conv_req  <= 1'b0;
      conv_ch   <= '0;
      last_q    <= '0;
      endless_q <= 1'b0;
      rep_q     <= 1'b0;
      rep_cnt   <= '0;
      nack_seen <= 1'b0;
      seq_done  <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_CONV;
            conv_req  <= 1'b1;
            conv_ch   <= first_ch;
            last_q    <= last_ch;
            endless_q <= endless;
            rep_q     <= rep_mode;
            rep_cnt   <= '0;
            nack_seen <= 1'b0;
          end
        end
        ST_CONV: begin
          if (nack) nack_seen <= 1'b1;
          if (conv_done) begin
            if (finish) begin
              state    <= ST_IDLE;
              conv_req <= 1'b0;
              seq_done <= 1'b1;
            end else if (rep_q) begin
              rep_cnt <= rep_cnt + CNT_W'(1);
            end else if (!endless_q) begin
              conv_ch <= conv_ch + SEL_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_CONV);

  // R1: no request outside a run
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !conv_req);

  // R10: request and channel hold until the converter answers
  a_r10_hold_req: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done) |=> (conv_req && $stable(conv_ch)));

  // R11: end pulse lasts one cycle and coincides with idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (!busy && !conv_req));

  // R9: a not-acknowledge with a completing conversion ends the run
  a_r9_nack_end: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_done && nack) |=> (!busy && seq_done));

  // R12: a start during a run does not restart the channel walk
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !conv_done) |=> $stable(conv_ch));

endmodule

// File: rtl/adc_scan_result.sv
`timescale 1ns/1ps
module adc_scan_result #(
  parameter int SEL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [SEL_W-1:0]  ch_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              valid,
  output logic [SEL_W-1:0]  ch_out,
  output logic [DATA_W-1:0] data_out
);

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else     valid <= capture;
  end

  // Payload registers carry no reset so they map onto plain fabric flops
  always_ff @(posedge clk) begin
    if (capture) begin
      ch_out   <= ch_in;
      data_out <= data_in;
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 12,
  parameter int DATA_W   = 8,
  parameter int REPEAT_N = 8,
  localparam int SEL_W   = sel_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        scan_mode,
  input  logic [SEL_W-1:0]  ch_sel,
  input  logic              ext_clk,
  input  logic              nack,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_req,
  output logic [SEL_W-1:0]  conv_ch,
  output logic              busy,
  output logic              seq_done,
  output logic              result_valid,
  output logic [SEL_W-1:0]  result_ch,
  output logic [DATA_W-1:0] result_data
);

  localparam int START_CH = mid_start(NUM_CH);
  localparam logic [SEL_W-1:0] MAX_CH = SEL_W'(NUM_CH - 1);

  logic [SEL_W-1:0] first_ch;
  logic [SEL_W-1:0] last_ch;
  logic             endless;
  logic             rep_mode;
  logic             capture;

  adc_scan_cfg #(
    .NUM_CH   (NUM_CH),
    .SEL_W    (SEL_W),
    .START_CH (START_CH)
  ) u_cfg (
    .mode     (scan_mode),
    .sel      (ch_sel),
    .ext_clk  (ext_clk),
    .first_ch (first_ch),
    .last_ch  (last_ch),
    .endless  (endless),
    .rep_mode (rep_mode)
  );

  adc_scan_ctrl #(
    .SEL_W    (SEL_W),
    .REPEAT_N (REPEAT_N)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .first_ch  (first_ch),
    .last_ch   (last_ch),
    .endless   (endless),
    .rep_mode  (rep_mode),
    .nack      (nack),
    .conv_done (conv_done),
    .conv_req  (conv_req),
    .conv_ch   (conv_ch),
    .busy      (busy),
    .seq_done  (seq_done)
  );

  assign capture = conv_req & conv_done;

  adc_scan_result #(
    .SEL_W  (SEL_W),
    .DATA_W (DATA_W)
  ) u_res (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .ch_in    (conv_ch),
    .data_in  (conv_data),
    .valid    (result_valid),
    .ch_out   (result_ch),
    .data_out (result_data)
  );

  // R7: requested channel stays inside the variant's range
  a_r7_ch_range: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> (conv_ch <= MAX_CH));

  // R13: the answered conversion appears on the result port one cycle later
  a_r13_capture: assert property (@(posedge clk) disable iff (rst)
    (conv_req && conv_done) |=> (result_valid && result_ch == $past(conv_ch)
                                 && result_data == $past(conv_data)));

  // R13: no result without a completed conversion
  a_r13_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(conv_req && conv_done) |=> !result_valid);

endmodule

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_conv_model (
  input  logic       clk,
  input  logic       clr,
  input  logic       conv_req,
  input  logic [3:0] conv_ch,
  output logic       conv_done,
  output logic [7:0] conv_data
);
  int         ch_log [0:63];
  int         log_n;
  int         wait_cnt;
  logic [3:0] last_ch;
  logic [7:0] last_data;

  initial begin
    conv_done = 1'b0;
    conv_data = 8'h00;
    log_n     = 0;
    wait_cnt  = 0;
    last_ch   = 4'h0;
    last_data = 8'h00;
  end

  always @(negedge clk) begin
    if (clr) begin
      log_n    = 0;
      wait_cnt = 0;
    end
    if (conv_done) begin
      conv_done = 1'b0;
      wait_cnt  = 0;
    end else if (conv_req) begin
      if (wait_cnt == 1) begin
        conv_data = {conv_ch, 4'(log_n)};
        conv_done = 1'b1;
        last_ch   = conv_ch;
        last_data = conv_data;
        if (log_n < 64) ch_log[log_n] = int'(conv_ch);
        log_n    = log_n + 1;
        wait_cnt = 0;
      end else begin
        wait_cnt = wait_cnt + 1;
      end
    end
  end
endmodule

module sim_adc_scan_seq;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start0 = 1'b0, start1 = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [3:0] sel = 4'h0;
  logic       ext = 1'b0;
  logic       nack = 1'b0;
  logic       clr = 1'b0;

  logic       req0, busy0, done0, rv0, cd0;
  logic [3:0] ch0, rch0;
  logic [7:0] rd0, dat0;
  logic       req1, busy1, done1, rv1, cd1;
  logic [1:0] ch1, rch1;
  logic [7:0] rd1, dat1;

  int total = 0;
  int bad   = 0;
  int dcnt0 = 0;
  int dcnt1 = 0;
  int exp_ch [0:63];

  always #(CLK_P/2) clk = ~clk;

  adc_scan_seq #(.NUM_CH(12)) u0 (
    .clk(clk), .rst(rst), .start(start0), .scan_mode(mode), .ch_sel(sel),
    .ext_clk(ext), .nack(nack), .conv_done(cd0), .conv_data(dat0),
    .conv_req(req0), .conv_ch(ch0), .busy(busy0), .seq_done(done0),
    .result_valid(rv0), .result_ch(rch0), .result_data(rd0));

  adc_scan_seq #(.NUM_CH(4)) u1 (
    .clk(clk), .rst(rst), .start(start1), .scan_mode(mode), .ch_sel(sel[1:0]),
    .ext_clk(ext), .nack(nack), .conv_done(cd1), .conv_data(dat1),
    .conv_req(req1), .conv_ch(ch1), .busy(busy1), .seq_done(done1),
    .result_valid(rv1), .result_ch(rch1), .result_data(rd1));

  sim_conv_model r0 (.clk(clk), .clr(clr), .conv_req(req0), .conv_ch(ch0),
                     .conv_done(cd0), .conv_data(dat0));
  sim_conv_model r1 (.clk(clk), .clr(clr), .conv_req(req1), .conv_ch({2'b00, ch1}),
                     .conv_done(cd1), .conv_data(dat1));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // R13: result port mirrors the last answered conversion
  always @(negedge clk) begin
    if (!rst && rv0) begin
      chk(rch0 == r0.last_ch, "R13", "u0 result_ch", int'(rch0), int'(r0.last_ch));
      chk(rd0 == r0.last_data, "R13", "u0 result_data", int'(rd0), int'(r0.last_data));
    end
    if (!rst && rv1) begin
      chk({2'b00, rch1} == r1.last_ch, "R13", "u1 result_ch", int'(rch1), int'(r1.last_ch));
      chk(rd1 == r1.last_data, "R13", "u1 result_data", int'(rd1), int'(r1.last_data));
    end
    if (done0) dcnt0++;
    if (done1) dcnt1++;
  end

  function automatic int build_exp(input int nch, input int m, input int s);
    int mx = nch - 1;
    int sc = (s > mx) ? mx : s;
    int st = (nch > 4) ? 6 : 2;
    int n  = 0;
    case (m)
      0: for (int i = 0; i <= sc; i++) begin exp_ch[n] = i; n++; end
      1: for (int i = 0; i < 8; i++) begin exp_ch[n] = sc; n++; end
      2: for (int i = st; i <= ((sc > st) ? sc : st); i++) begin exp_ch[n] = i; n++; end
      default: begin exp_ch[0] = sc; n = 1; end
    endcase
    return n;
  endfunction

  task automatic clear_logs();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_end(input int which, input int d_before, input string req);
    int got = 0;
    for (int i = 0; i < 3000 && got == 0; i++) begin
      @(negedge clk);
      if ((which == 0 ? dcnt0 : dcnt1) != d_before) got = 1;
    end
    chk(got == 1, req, "run ended", got, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(input int which, input int n, input int d_before, input string req);
    int ln = (which == 0) ? r0.log_n : r1.log_n;
    int dn = ((which == 0) ? dcnt0 : dcnt1) - d_before;
    chk(ln == n, req, "conversion count", ln, n);
    for (int i = 0; i < n && i < ln && i < 64; i++) begin
      int a = (which == 0) ? r0.ch_log[i] : r1.ch_log[i];
      chk(a == exp_ch[i], req, $sformatf("channel of step %0d", i), a, exp_ch[i]);
    end
    chk(dn == 1, "R11", "seq_done pulses", dn, 1);
    chk(((which == 0) ? busy0 : busy1) == 1'b0, "R11", "busy after end",
        int'((which == 0) ? busy0 : busy1), 0);
  endtask

  task automatic run_seq(input int which, input int m, input int s, input bit e,
                         input int nack_after, input string req);
    int n;
    int d_before;
    int nch = (which == 0) ? 12 : 4;
    int mx  = nch - 1;
    int sc  = (s > mx) ? mx : s;
    clear_logs();
    n = build_exp(nch, m, s);
    if (e && (m == 1 || m == 3)) begin
      n = nack_after + 1;
      for (int i = 0; i < n; i++) exp_ch[i] = sc;
    end else if (nack_after >= 0 && nack_after + 1 < n) begin
      n = nack_after + 1;
    end
    d_before = (which == 0) ? dcnt0 : dcnt1;
    mode = 2'(m); sel = 4'(s); ext = e;
    if (which == 0) start0 = 1'b1; else start1 = 1'b1;
    @(negedge clk);
    start0 = 1'b0; start1 = 1'b0;
    if (nack_after >= 0) begin
      if (which == 0) wait (r0.log_n == nack_after);
      else            wait (r1.log_n == nack_after);
      @(negedge clk); nack = 1'b1;
      @(negedge clk); nack = 1'b0;
    end
    wait_end(which, d_before, req);
    compare(which, n, d_before, req);
    ext = 1'b0;
  endtask

  task automatic t_reset();
    chk(req0 == 1'b0, "R1", "u0 conv_req", int'(req0), 0);
    chk(busy0 == 1'b0, "R1", "u0 busy", int'(busy0), 0);
    chk(done0 == 1'b0, "R1", "u0 seq_done", int'(done0), 0);
    chk(rv0 == 1'b0, "R1", "u0 result_valid", int'(rv0), 0);
    chk(req1 == 1'b0 && busy1 == 1'b0, "R1", "u1 idle", int'(busy1), 0);
  endtask

  // R12: configuration change and a second start during a run are ignored
  task automatic t_cfg_change();
    int n;
    int d_before;
    clear_logs();
    n = build_exp(12, 0, 3);
    d_before = dcnt0;
    mode = 2'b00; sel = 4'd3; ext = 1'b0;
    start0 = 1'b1;
    @(negedge clk); start0 = 1'b0;
    @(negedge clk);
    mode = 2'b11; sel = 4'd9; ext = 1'b1; start0 = 1'b1;
    @(negedge clk); start0 = 1'b0;
    wait_end(0, d_before, "R12");
    compare(0, n, d_before, "R12");
    ext = 1'b0;
  endtask

  // R9: not-acknowledge while idle leaves no trace
  task automatic t_nack_idle();
    @(negedge clk); nack = 1'b1;
    @(negedge clk); nack = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy0 == 1'b0 && req0 == 1'b0, "R9", "idle after stray nack", int'(busy0), 0);
    run_seq(0, 3, 7, 1'b0, -1, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_seq(0, 0, 4, 1'b0, -1, "R2");
    run_seq(0, 0, 0, 1'b0, -1, "R2");
    run_seq(0, 1, 5, 1'b0, -1, "R3");
    run_seq(0, 2, 9, 1'b0, -1, "R4");
    run_seq(1, 2, 3, 1'b0, -1, "R4");
    run_seq(0, 2, 3, 1'b0, -1, "R5");
    run_seq(0, 2, 6, 1'b0, -1, "R5");
    run_seq(1, 2, 1, 1'b0, -1, "R5");
    run_seq(0, 3, 7, 1'b0, -1, "R6");
    run_seq(0, 0, 14, 1'b0, -1, "R7");
    run_seq(0, 2, 15, 1'b0, -1, "R7");
    run_seq(0, 1, 10, 1'b1, 5, "R8");
    run_seq(0, 3, 2, 1'b1, 3, "R8");
    run_seq(0, 0, 8, 1'b0, 2, "R9");
    run_seq(0, 1, 4, 1'b0, 1, "R9");
    run_seq(1, 0, 3, 1'b0, -1, "R2");
    t_cfg_change();
    t_nack_idle();
    run_seq(0, 2, 11, 1'b0, -1, "R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule